// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is an 8-bit up-counting watchdog timer driven through a power-of-two prescaler. Software sees it as two byte-wide registers behind a small write/read bus. The first is a count register. The second is a control register that holds the enable, the overflow action, the overflow flag and the prescaler selection. A write changes a register only when the upper byte of the bus word carries that register's own key value. Any other write, including one that carries the other register's key, is dropped without effect.

The count advances once per prescaler tick while the timer is enabled. When it wraps past its top value, the block raises the overflow flag. The mode bit then decides what the wrap does. In interval mode the flag drives a level interrupt. In watchdog mode the wrap starts a reset-request pulse of fixed length. Software keeps the watchdog from firing by rewriting the count before it wraps.

A parameter selects the bus width. A 16-bit bus carries the key in bits 15:8, and a 32-bit bus carries it in bits 31:24. The data byte is bits 7:0 in both cases.

Top module: `keyed_wdt`

## Requirements
- R1: A write with `bus_sel`=0 changes the count only when the key byte equals 0x5A. The new count is then bits 7:0 of `bus_wdata`, visible from the next cycle.
- R2: A write with `bus_sel`=1 changes the control register only when the key byte equals 0xA5. The control layout is: bit 7 enable, bit 6 mode (1 = watchdog, 0 = interval), bit 5 overflow flag, bits 4:3 reserved and read as 0, bits 2:0 prescaler select.
- R3: A write whose key byte is wrong for the selected register, including the other register's key, changes no count, control, flag or prescaler state.
- R4: `bus_rdata` shows the count when `bus_sel`=0 and the control register when `bus_sel`=1. It is combinational and 8 bits wide, and it carries no key.
- R5: Select code k gives a prescaler ratio of 32·2^k, from 32 up to 4096. After enabling at a write edge E, the count steps at edges E+ratio, E+2·ratio, and so on.
- R6: After reset the count, the enable, the mode, the flag and the select all read 0, and both outputs are low.
- R7: A step from 0xFF wraps the count to 0x00 and sets the flag. A keyed control write with bit 5 = 0 clears the flag, and bit 5 = 1 leaves it as it is. An overflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly while the flag is set and the mode is interval.
- R9: In watchdog mode an overflow drives `rst_req` high for exactly RST_PULSE_CYC cycles, starting the cycle after the wrapping edge.
- R10: The prescaler restarts from zero on a keyed control write that changes the select field or clears the enable. While the timer is disabled, the prescaler stays at zero.
- R11: A keyed count write in the same cycle as a prescaler tick wins, and the written value is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | Register select: 0 count, 1 control |
| bus_wdata | input | BUS_W | Write word: key byte on top, data byte in bits 7:0 |
| bus_rdata | output | 8 | Selected register byte |
| irq | output | 1 | Interval-mode overflow interrupt (level) |
| rst_req | output | 1 | Watchdog-mode reset request pulse |

## Verification
The counting path is driven with a count preset just below the wrap, so the interval and watchdog overflow actions can be told apart by which output moves and when. Key patterns include the correct key, a random wrong byte and the other register's key. These separate a register-specific key check from a check that accepts either key. Select changes and disables made in mid-period show whether the prescaler really restarts. Wide select codes, up to 4096, check the ratio table. A long pseudo-random stream of keyed and unkeyed writes is compared against a behavioural model on every clock. That stream catches count writes that collide with ticks, and flag clears that collide with overflows.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam logic [7:0] KEY_COUNT = 8'h5A;
   localparam logic [7:0] KEY_CTRL  = 8'hA5;
   localparam int EN_BIT   = 7;
   localparam int MODE_BIT = 6;
   localparam int FLAG_BIT = 5;
endpackage

// File: rtl/kwdt_decode.sv
module kwdt_decode #(
   parameter int BUS_W = 16
) (
   input  logic             bus_wr,
   input  logic             bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic             cnt_we,
   output logic             ctl_we,
   output logic [7:0]       wbyte
);
   import kwdt_pkg::*;
   logic [7:0] key;

   generate
      if (BUS_W == 16) begin : g_narrow
         assign key = bus_wdata[15:8];
      end else if (BUS_W == 32) begin : g_wide
         logic unused_mid;
         assign key        = bus_wdata[31:24];
         assign unused_mid = ^bus_wdata[23:8];
      end else begin : g_bad
         $error("kwdt_decode: BUS_W must be 16 or 32");
      end
   endgenerate

   assign wbyte  = bus_wdata[7:0];
   assign cnt_we = bus_wr && !bus_sel && (key == KEY_COUNT);
   assign ctl_we = bus_wr &&  bus_sel && (key == KEY_CTRL);
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int BASE_LOG2 = 5,
   parameter int SEL_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] cks,
   input  logic             ctl_we,
   input  logic [7:0]       wbyte,
   output logic             tick
);
   localparam int PW = BASE_LOG2 + (1 << SEL_W) - 1;

   logic [PW-1:0] pcnt;
   logic [PW-1:0] limit;
   logic          restart;

   assign limit   = ({{(PW-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(cks))) - 1'b1;
   assign tick    = en && (pcnt == limit);
   assign restart = ctl_we && ((wbyte[SEL_W-1:0] != cks) || !wbyte[kwdt_pkg::EN_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (restart || !en)   pcnt <= '0;
      else if (tick)             pcnt <= '0;
      else                       pcnt <= pcnt + 1'b1;
   end

   // R10: a disabled timer keeps the divider at zero, so no tick appears next cycle
   a_r10_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ctl_we) |=> !tick);
   // R10: a restarting write leaves the divider at zero
   a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0));
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic             ctl_we,
   input  logic [7:0]       wbyte,
   output logic [7:0]       cnt_q,
   output logic             en_q,
   output logic             mode_q,
   output logic             flag_q,
   output logic [SEL_W-1:0] cks_q,
   output logic             ovf
);
   import kwdt_pkg::*;

   assign ovf = tick && (cnt_q == 8'hFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_we) cnt_q <= wbyte;
      else if (tick)   cnt_q <= cnt_q + 8'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         cks_q  <= '0;
      end else if (ctl_we) begin
         en_q   <= wbyte[EN_BIT];
         mode_q <= wbyte[MODE_BIT];
         cks_q  <= wbyte[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            flag_q <= 1'b0;
      else if (ovf)                          flag_q <= 1'b1;
      else if (ctl_we && !wbyte[FLAG_BIT])   flag_q <= 1'b0;
   end

   // R11: a keyed count write is loaded even when a tick coincides
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_q == $past(wbyte)));
   // R3: without a keyed write or a tick the count holds
   a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_we && !tick) |=> $stable(cnt_q));
   // R7: a wrap leaves the flag set
   a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flag_q);
endmodule

// File: rtl/kwdt_rstgen.sv
module kwdt_rstgen #(
   parameter int PULSE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic rst_req
);
   localparam int CW = $clog2(PULSE + 1);
   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left <= '0;
      else if (fire)         left <= CW'(PULSE);
      else if (left != '0)   left <= left - 1'b1;
   end

   assign rst_req = (left != '0);

   // R9: an overflow in watchdog mode raises the request on the next cycle
   a_r9_fire_raises: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rst_req);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
   parameter int BUS_W         = 16,
   parameter int BASE_LOG2     = 5,
   parameter int SEL_W         = 3,
   parameter int RST_PULSE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             irq,
   output logic             rst_req
);
   localparam int RSV_W = 5 - SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("keyed_wdt: SEL_W must be 1..4");
      end
      if (RST_PULSE_CYC < 1) begin : g_bad_pulse
         $error("keyed_wdt: RST_PULSE_CYC must be at least 1");
      end
   endgenerate

   logic             cnt_we, ctl_we, tick, ovf;
   logic [7:0]       wbyte, cnt_q;
   logic             en_q, mode_q, flag_q;
   logic [SEL_W-1:0] cks_q;

   kwdt_decode #(.BUS_W(BUS_W)) u_decode (
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .cnt_we(cnt_we), .ctl_we(ctl_we), .wbyte(wbyte)
   );

   kwdt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(en_q), .cks(cks_q),
      .ctl_we(ctl_we), .wbyte(wbyte), .tick(tick)
   );

   kwdt_core #(.SEL_W(SEL_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .ctl_we(ctl_we),
      .wbyte(wbyte), .cnt_q(cnt_q), .en_q(en_q), .mode_q(mode_q),
      .flag_q(flag_q), .cks_q(cks_q), .ovf(ovf)
   );

   kwdt_rstgen #(.PULSE(RST_PULSE_CYC)) u_rstgen (
      .clk(clk), .rst_n(rst_n), .fire(ovf && mode_q), .rst_req(rst_req)
   );

   assign bus_rdata = bus_sel ? {en_q, mode_q, flag_q, {RSV_W{1'b0}}, cks_q} : cnt_q;
   assign irq       = flag_q && !mode_q;

   // R8: the interrupt is silent in watchdog mode
   a_r8_no_irq_in_wdog: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> !irq);
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
   localparam int PULSE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sel = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq, rst_req;

   int checks = 0;
   int failures = 0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   keyed_wdt #(.BUS_W(16), .RST_PULSE_CYC(PULSE)) u_keyed_wdt (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
   );

   // behavioural reference model
   int m_cnt, m_p, m_cks, m_rl;
   bit m_en, m_mode, m_flag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_p = 0; m_cks = 0; m_rl = 0;
         m_en = 0; m_mode = 0; m_flag = 0;
      end else begin
         int  n_cnt, n_p, n_cks, n_rl, ratio, wb, key;
         bit  n_en, n_mode, n_flag, tk, ov;
         ratio = 32 * (2 ** m_cks);
         tk = m_en && (m_p == ratio - 1);
         ov = tk && (m_cnt == 255);
         n_cnt = tk ? (m_cnt + 1) % 256 : m_cnt;
         n_p = !m_en ? 0 : (tk ? 0 : m_p + 1);
         n_en = m_en; n_mode = m_mode; n_cks = m_cks; n_flag = m_flag;
         n_rl = (m_rl > 0) ? m_rl - 1 : 0;
         wb = int'(bus_wdata[7:0]);
         key = int'(bus_wdata[15:8]);
         if (bus_wr && !bus_sel && key == 'h5A) n_cnt = wb;
         if (bus_wr && bus_sel && key == 'hA5) begin
            n_en = wb[7]; n_mode = wb[6]; n_cks = wb % 8;
            if (!wb[5]) n_flag = 0;
            if (n_cks != m_cks || !n_en) n_p = 0;
         end
         if (ov) n_flag = 1;
         if (ov && m_mode) n_rl = PULSE;
         m_cnt = n_cnt; m_p = n_p; m_cks = n_cks; m_rl = n_rl;
         m_en = n_en; m_mode = n_mode; m_flag = n_flag;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         int exp_rd;
         exp_rd = bus_sel ? ((int'(m_en) << 7) | (int'(m_mode) << 6) | (int'(m_flag) << 5) | m_cks)
                          : m_cnt;
         chk("R4 model rdata", int'(bus_rdata), exp_rd);
         chk("R8 model irq", int'(irq), int'(m_flag && !m_mode));
         chk("R9 model rst_req", int'(rst_req), int'(m_rl > 0));
      end
   end

   task automatic wr(input bit sel, input logic [7:0] key, input logic [7:0] dat);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = {key, dat};
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic rd(input bit sel, output int v);
      bus_sel = sel; #1;
      v = int'(bus_rdata);
   endtask

   initial begin
      int v, c0;
      int unsigned lcg;
      cmp_on = 1'b1;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R6 reset state
      rd(0, v); chk("R6 count after reset", v, 0);
      rd(1, v); chk("R6 control after reset", v, 0);
      chk("R6 irq after reset", int'(irq), 0);
      chk("R6 rst_req after reset", int'(rst_req), 0);
      // R3 wrong keys
      wr(0, 8'h33, 8'h44); rd(0, v); chk("R3 count wrong key", v, 0);
      wr(0, 8'hA5, 8'h44); rd(0, v); chk("R3 count with control key", v, 0);
      wr(1, 8'h5A, 8'h80); rd(1, v); chk("R3 control with count key", v, 0);
      // R1 keyed count write
      wr(0, 8'h5A, 8'hFE); rd(0, v); chk("R1 keyed count write", v, 'hFE);
      // R5/R7/R8 interval mode, ratio 32
      wr(1, 8'hA5, 8'h80);
      idle(63); rd(0, v); chk("R5 count before second tick", v, 'hFF);
      rd(1, v); chk("R2 control enabled", v, 'h80);
      idle(1); rd(0, v); chk("R7 wrap to zero", v, 0);
      rd(1, v); chk("R7 flag set on wrap", v, 'hA0);
      chk("R8 irq in interval mode", int'(irq), 1);
      wr(1, 8'hA5, 8'hA0); rd(1, v); chk("R7 writing 1 keeps flag", v, 'hA0);
      wr(1, 8'hA5, 8'h80); rd(1, v); chk("R7 writing 0 clears flag", v, 'h80);
      chk("R8 irq low after clear", int'(irq), 0);
      // R10 select change restarts the divider
      idle(20);
      wr(1, 8'hA5, 8'h81); rd(0, c0);
      idle(63); rd(0, v); chk("R10 no step before full ratio 64", v, c0);
      idle(1); rd(0, v); chk("R10 step at ratio 64 after restart", v, (c0 + 1) % 256);
      idle(30);
      wr(1, 8'hA5, 8'h01); wr(1, 8'hA5, 8'h81); rd(0, c0);
      idle(63); rd(0, v); chk("R10 enable toggle restarts", v, c0);
      idle(1); rd(0, v); chk("R10 step after re-enable", v, (c0 + 1) % 256);
      // R2 reserved bits, flag write with flag clear
      wr(1, 8'hA5, 8'h1F); rd(1, v); chk("R2 reserved read zero", v, 'h07);
      // R5 ratio 4096
      wr(0, 8'h5A, 8'h10);
      wr(1, 8'hA5, 8'h87);
      idle(4095); rd(0, v); chk("R5 no step before 4096", v, 'h10);
      idle(1); rd(0, v); chk("R5 step at 4096", v, 'h11);
      // R9 watchdog pulse
      wr(1, 8'hA5, 8'h00);
      wr(0, 8'h5A, 8'hFF);
      wr(1, 8'hA5, 8'hC0);
      idle(31); chk("R9 rst_req before wrap", int'(rst_req), 0);
      idle(1); chk("R9 rst_req raised", int'(rst_req), 1);
      rd(1, v); chk("R9 flag set in watchdog mode", v, 'hE0);
      chk("R8 no irq in watchdog mode", int'(irq), 0);
      idle(PULSE - 1); chk("R9 rst_req still high", int'(rst_req), 1);
      idle(1); chk("R9 rst_req pulse ended", int'(rst_req), 0);
      wr(1, 8'hA5, 8'h00);
      // R11 and mixed stream against the model
      lcg = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
         int r, kk;
         logic [7:0] key, dat;
         lcg = lcg * 1103515245 + 12345;
         r = int'(lcg >> 8);
         kk = r % 4;
         key = (kk == 0) ? 8'h5A : (kk == 1) ? 8'hA5 : (kk == 2) ? 8'h5A : 8'(r >> 4);
         if (((r >> 2) % 2) == 1) begin
            dat = 8'hF8 | 8'((r >> 12) % 8);
            bus_sel = 1'b0;
            wr(0, key, dat);
         end else begin
            dat = {1'b1, 1'(r >> 13), 1'(r >> 14), 2'(r >> 15), 2'b0, 1'(r >> 17)};
            if (((r >> 18) % 8) == 0) dat[7] = 1'b0;
            wr(1, key, dat);
         end
         idle((r >> 20) % 40);
      end
      idle(5);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1500000;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule